// File: doc/BRIEF.md
# Interlace-aware framebuffer scan address generator

This block generates the 32-bit-word read addresses that a display pipeline needs to fetch a raster image from a framebuffer. A packed window-size word sets the geometry. Its top ten bits hold a word modulo, its middle ten bits hold the number of stored lines minus one, and its low ten bits hold the line width in 32-bit words minus one. Two start addresses are supplied, one for the long field and one for the short field. A timing generator supplies vertical blank, a line-start pulse and a field flag. Each line-start pulse makes the block fetch one line, word by word, over a request/grant handshake with memory.

For interlaced output, software programs the height of one field and raises the modulo by one line length in words. Each field then steps over the lines of the other field. Line doubling fetches every stored line twice. Horizontal pixel doubling paces requests so that no two are accepted back to back, because the pixel stage consumes each word at half rate. The block takes the start address, the geometry and the mode bits into shadow registers only while vertical blank is high. Panning writes therefore take effect at the next field and never split the field in progress.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset, mem_req and fetch_busy are low.
- R2: The first word of a field is fetched from base_short when interlace_en and field_odd were both 1 during vertical blank, and from base_long otherwise.
- R3: Within a line, the block requests (win_size[9:0] + 1) words at consecutive addresses. mem_addr holds while a request is not granted, and mem_req drops after the last word is granted.
- R4: Each new stored line starts at the address of the previous line's last word plus the modulo in win_size[29:20].
- R5: A field holds (win_size[19:10] + 1) stored lines. After the last of them, line_start pulses cause no request until the next vertical blank.
- R6: With pixel doubling enabled, no request is accepted in the cycle that follows an accepted request.
- R7: With line doubling enabled, each stored line is fetched twice from the same addresses before the block advances to the next line.
- R8: The start addresses, geometry and mode inputs take effect only while vblank is high. Changes made outside vblank do not affect the current field, and vblank ends any fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_size | input | 30 | Modulo [29:20], lines minus one [19:10], words per line minus one [9:0] |
| base_long | input | ADDR_W | Word start address of the long field |
| base_short | input | ADDR_W | Word start address of the short field |
| interlace_en | input | 1 | Enable selection of the start address by field |
| line_dbl_en | input | 1 | Fetch each stored line twice |
| pix_dbl_en | input | 1 | Pace requests for horizontal pixel doubling |
| vblank | input | 1 | Vertical blank; loads the shadows and resets the field |
| line_start | input | 1 | One-cycle pulse that starts the fetch of a line |
| field_odd | input | 1 | Field flag; 1 selects the short field |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_gnt | input | 1 | Memory accepts the request in this cycle |
| mem_last | output | 1 | The current request is the last word of the line |
| fetch_busy | output | 1 | A line fetch is in progress |

## Verification
The bench sweeps line widths down to a single word, heights down to a single line, zero and interlace-sized modulos, and every combination of the interlace, field, line-doubling and pixel-doubling settings, each under several grant patterns. An off-by-one in the word count would show up as a missing or extra word. A wrong modulo step would give a first word of a line at the wrong address. A repeat counter that never cleared would fetch a doubled line a third time or skip the repeat. Right after each vertical blank the bench scrambles the start addresses and geometry. A design that read these inputs directly, without shadows, would then fetch from the wrong place or fetch the wrong number of words. A line_start sent after the final line exposes a line counter that fails to stop at the programmed height.

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int FLD_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3*FLD_W-1:0] win_size,
  input  logic [ADDR_W-1:0] base_long,
  input  logic [ADDR_W-1:0] base_short,
  input  logic              interlace_en,
  input  logic              line_dbl_en,
  input  logic              pix_dbl_en,
  input  logic              vblank,
  input  logic              line_start,
  input  logic              field_odd,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  output logic              mem_last,
  output logic              fetch_busy
);
  localparam int MOD_LSB = 2*FLD_W;
  localparam int HGT_LSB = FLD_W;

  logic [FLD_W-1:0]  mod_q, hgt_q, wid_q, wcnt, lcnt;
  logic              dbl_q, pd_q, rep, busy, gap, done;
  logic [ADDR_W-1:0] line_base, addr_q;
  logic              accept;

  assign mem_req    = busy && !gap;
  assign mem_addr   = addr_q;
  assign mem_last   = mem_req && (wcnt == wid_q);
  assign fetch_busy = busy;
  assign accept     = mem_req && mem_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q     <= '0;
      hgt_q     <= '0;
      wid_q     <= '0;
      dbl_q     <= 1'b0;
      pd_q      <= 1'b0;
      line_base <= '0;
      addr_q    <= '0;
      wcnt      <= '0;
      lcnt      <= '0;
      rep       <= 1'b0;
      busy      <= 1'b0;
      gap       <= 1'b0;
      done      <= 1'b0;
    end else if (vblank) begin
      mod_q     <= win_size[MOD_LSB +: FLD_W];
      hgt_q     <= win_size[HGT_LSB +: FLD_W];
      wid_q     <= win_size[0 +: FLD_W];
      dbl_q     <= line_dbl_en;
      pd_q      <= pix_dbl_en;
      line_base <= (interlace_en && field_odd) ? base_short : base_long;
      wcnt      <= '0;
      lcnt      <= '0;
      rep       <= 1'b0;
      busy      <= 1'b0;
      gap       <= 1'b0;
      done      <= 1'b0;
    end else begin
      gap <= accept && pd_q;
      if (!busy && line_start && !done) begin
        busy   <= 1'b1;
        addr_q <= line_base;
        wcnt   <= '0;
      end else if (accept) begin
        if (wcnt == wid_q) begin
          busy <= 1'b0;
          if (dbl_q && !rep) begin
            rep <= 1'b1;
          end else begin
            rep       <= 1'b0;
            line_base <= line_base + ADDR_W'(wid_q) + ADDR_W'(mod_q);
            lcnt      <= lcnt + 1'b1;
            if (lcnt == hgt_q) done <= 1'b1;
          end
        end else begin
          addr_q <= addr_q + 1'b1;
          wcnt   <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vblank,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_last,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pd_q
);
  a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_last && !vblank) |=> (mem_addr == $past(mem_addr) + 1'b1));

  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !vblank) |=> $stable(mem_addr));

  a_r3_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_last) |=> !mem_req);

  a_r6_pacing: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && pd_q && !vblank) |=> !mem_req);

  a_r8_vblank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> !mem_req);
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_last(mem_last), .mem_addr(mem_addr), .pd_q(pd_q)
);

// File: tb/tb_scan_addr_gen.sv
module tb_scan_addr_gen;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0;
  logic [29:0] win_size = '0;
  logic [AW-1:0] base_long = '0, base_short = '0;
  logic interlace_en = 0, line_dbl_en = 0, pix_dbl_en = 0;
  logic vblank = 0, line_start = 0, field_odd = 0, mem_gnt = 0;
  logic mem_req, mem_last, fetch_busy;
  logic [AW-1:0] mem_addr;
  int checks = 0, errors = 0, cycles = 0, words = 0;

  always #5 clk = ~clk;

  scan_addr_gen #(.ADDR_W(AW)) dut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fetch_line(input int base, input int w, input bit pd, input int gm, input string tag0);
    int idx = 0, cyc = 0;
    bit prev_acc = 0, g;
    line_start = 1;
    while (idx <= w && cyc < 300) begin
      @(negedge clk);
      line_start = 0;
      cyc++;
      if (prev_acc && pd) check(!mem_req, "R6", mem_req, 0);
      g = (gm == 0) ? 1'b1 : (gm == 1) ? 1'(cyc % 2) : (cyc % 3 != 0);
      if (mem_req) check(mem_addr == AW'(base + idx), (idx == 0) ? tag0 : "R3", mem_addr, AW'(base + idx));
      mem_gnt = g;
      prev_acc = mem_req && g;
      if (prev_acc) begin
        idx++;
        words++;
      end
    end
    if (cyc >= 300) check(0, "R3 line timeout", idx, w + 1);
    @(negedge clk);
    mem_gnt = 0;
    check(!mem_req, "R3 line length", mem_req, 0);
  endtask

  task automatic run_field(input int w, input int h, input int m, input bit il, input bit fo,
                           input bit ld, input bit pd, input int gm, input int bl, input int bs);
    int reps = ld ? 2 : 1;
    int start = (il && fo) ? bs : bl;
    int total = (h + 1) * reps;
    @(negedge clk);
    win_size = {10'(m), 10'(h), 10'(w)};
    base_long = AW'(bl); base_short = AW'(bs);
    interlace_en = il; field_odd = fo; line_dbl_en = ld; pix_dbl_en = pd;
    vblank = 1;
    @(negedge clk); @(negedge clk);
    vblank = 0;
    win_size = {10'd7, 10'd9, 10'd11};
    base_long = 24'hABCDE0; base_short = 24'h55AA00;
    interlace_en = !il; field_odd = !fo; line_dbl_en = !ld; pix_dbl_en = !pd;
    words = 0;
    for (int dl = 0; dl < total; dl++) begin
      int s = dl / reps;
      string t = (dl == 0) ? "R2" : (dl % reps == 1) ? "R7" : "R4";
      fetch_line(start + s * (w + m), w, pd, gm, t);
      repeat (2) @(negedge clk);
    end
    check(words == total * (w + 1), "R8 word total", words, total * (w + 1));
    line_start = 1;
    @(negedge clk); line_start = 0;
    repeat (3) begin
      @(negedge clk);
      check(!mem_req && !fetch_busy, "R5", mem_req, 0);
    end
  endtask

  initial begin
    int run = 0;
    int ws[3] = '{0, 3, 6};
    repeat (3) @(negedge clk);
    check(!mem_req && !fetch_busy, "R1", {mem_req, fetch_busy}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!mem_req && !fetch_busy, "R1", {mem_req, fetch_busy}, 0);
    foreach (ws[i]) begin
      for (int h = 0; h < 3; h += 2) begin
        for (int f = 0; f < 16; f++) begin
          bit il = f[0], fo = f[1], ld = f[2], pd = f[3];
          int m = (f % 5 == 4) ? 0 : 1 + (il ? ws[i] + 1 : 0);
          run_field(ws[i], h, m, il, fo, ld, pd, (f + i) % 3,
                    'h1000 + run * 64, 'h80000 + run * 32);
          run++;
        end
      end
    end
    @(negedge clk);
    line_start = 1;
    vblank = 1;
    @(negedge clk);
    line_start = 0;
    @(negedge clk);
    check(!mem_req, "R8 vblank idle", mem_req, 0);
    vblank = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule